// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block is the coherence controller that sits between one processor and a shared broadcast bus in a small multiprocessor. It keeps one table entry per object, with a coherence state and a data value, and serves the processor's reads and writes from that table whenever the state allows it. When the state does not allow it, the controller asks an external arbiter for the bus and broadcasts a read request or a write request. It also watches every message that other controllers put on the bus and updates its own entries in response.

The bus carries three message kinds. A read request names an object. A write request names an object and announces that the sender is taking exclusive ownership. A value response names an object and carries its value. Transactions are never split: a read request is always followed by the value response before any other message uses the bus. Each controller has a source number, and it ignores messages that carry its own number. When several read-only holders could answer a read request, all of them ask for the bus. The arbiter grants the lowest-numbered one, and the others drop their pending answer when they see its value response.

The processor side accepts one request at a time and holds a busy flag until the request has completed. A completed read is signalled with a one-cycle valid strobe and its data.

Top module: `snc_top`

## Requirements
- R1: After reset every entry is Invalid, and `cpuBusy`, `busReq` and `outValid` are low.
- R2: A read of an entry in Read-only or Exclusive state makes no bus request. `cpuBusy` is high for one cycle, and in the following cycle `cpuRdValid` is high with the stored value on `cpuRdata`.
- R3: A write to an Exclusive entry makes no bus request and updates the stored value.
- R4: A write to a Read-only or Invalid entry raises `busReq`. On grant it drives a write request (kind code 2) with the object and the new data. The entry then becomes Exclusive with that value.
- R5: A read of an Invalid entry raises `busReq` and, on grant, drives a read request (kind code 1). It then waits for a value response (kind code 3) for that object from another source. It completes with that value and leaves the entry Read-only.
- R6: A write request from another source moves a Read-only or Exclusive entry for that object to Invalid. An Invalid entry stays Invalid.
- R7: A read request from another source for a Read-only or Exclusive entry raises `busReq`. On grant the controller drives a value response carrying the stored value. An Exclusive entry then becomes Read-only.
- R8: A pending value response is dropped, and `busReq` falls, when another source's value response for the same object appears first.
- R9: A value response from another source loads an Invalid entry for that object with the carried value and makes it Read-only, whether or not a read of that object is in progress.
- R10: Snooped messages whose source number equals the controller's own number (`MY_ID`) have no effect.
- R11: While the controller waits for a grant, it first applies any snooped message from another source, and then chooses its message from the updated state. A pending value response is sent before the processor's own request.
- R12: `cpuBusy` stays high from the cycle after a request is accepted until the request completes. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request strobe, taken when `cpuBusy` is low |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuObj | input | OBJ_W | Object identifier of the request |
| cpuWdata | input | DATA_W | Write data |
| cpuBusy | output | 1 | A request is in progress |
| cpuRdValid | output | 1 | One-cycle strobe for completed read data |
| cpuRdata | output | DATA_W | Read data |
| busReq | output | 1 | Request for bus ownership |
| busGrant | input | 1 | Bus granted this cycle |
| outValid | output | 1 | Controller drives a message this cycle |
| outKind | output | 2 | Kind of the driven message: 1 read request, 2 write request, 3 value response |
| outObj | output | OBJ_W | Object named by the driven message |
| outData | output | DATA_W | Value carried by a value response or a write request |
| outSrc | output | SRC_W | Source number of this controller |
| snpValid | input | 1 | A message is on the bus |
| snpKind | input | 2 | Kind of the observed message |
| snpObj | input | OBJ_W | Object named by the observed message |
| snpData | input | DATA_W | Value carried by the observed message |
| snpSrc | input | SRC_W | Source number of the observed message |

## Verification
The assertions assume that the environment respects the bus rules. A grant comes only in a cycle in which the controller is requesting, and the bus then carries only the controller's own message. A read request is answered by a value response before any other message appears. No other source sends a write request or read request that would break the single-Exclusive-holder rule. The bench plays the arbiter, the memory and the other caches. It grants only on a visible request and echoes the controller's own message onto the snoop bus during a grant. It injects foreign messages only in cycles without a grant. After each read request it injects the value response in the next cycle.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_RO  = 2'd1,
    ST_EX  = 2'd2
  } entState_e;

  typedef enum logic [1:0] {
    MSG_NONE = 2'd0,
    MSG_RR   = 2'd1,
    MSG_WR   = 2'd2,
    MSG_VR   = 2'd3
  } msgKind_e;

  typedef struct packed {
    logic latchOp;     // capture processor request
    logic localWrite;  // write op data into the op entry, make it Exclusive
    logic latchResp;   // remember object of a snooped read request
    logic sendVr;      // value response driven this cycle
    logic capHit;      // read data from the table
    logic capBus;      // read data from the snooped value response
  } ctlStrobe_t;

endpackage

// File: rtl/snc_entry.sv
module snc_entry
  import snc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpHit,
  input  logic [1:0]        snpKind,
  input  logic [DATA_W-1:0] snpData,
  input  logic              doWrite,
  input  logic [DATA_W-1:0] wrData,
  input  logic              doDowngrade,
  output entState_e         entSt,
  output logic [DATA_W-1:0] entVal
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entSt  <= ST_INV;
      entVal <= '0;
    end else if (snpHit) begin
      if (snpKind == MSG_WR) begin
        entSt <= ST_INV;
      end else if (snpKind == MSG_VR && entSt == ST_INV) begin
        entSt  <= ST_RO;
        entVal <= snpData;
      end
    end else if (doWrite) begin
      entSt  <= ST_EX;
      entVal <= wrData;
    end else if (doDowngrade && entSt == ST_EX) begin
      entSt <= ST_RO;
    end
  end

endmodule

// File: rtl/snc_datapath.sv
module snc_datapath
  import snc_pkg::*;
#(
  parameter int OBJ_W  = 3,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              cpuWrite,
  input  logic [OBJ_W-1:0]  cpuObj,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              snpValid,
  input  logic [1:0]        snpKind,
  input  logic [OBJ_W-1:0]  snpObj,
  input  logic [DATA_W-1:0] snpData,
  input  logic [SRC_W-1:0]  snpSrc,
  output logic              opWrite,
  output entState_e         opState,
  output logic              snpHitOp,
  output logic              snpRrHit,
  output logic              snpVrResp,
  output logic              snpVrOp,
  output logic [OBJ_W-1:0]  outObj,
  output logic [DATA_W-1:0] outData,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int NUM_OBJ = 1 << OBJ_W;

  logic [OBJ_W-1:0]  opObj;
  logic [DATA_W-1:0] opData;
  logic [OBJ_W-1:0]  respObj;
  entState_e         entSt  [NUM_OBJ];
  logic [DATA_W-1:0] entVal [NUM_OBJ];
  logic              foreignMsg;

  assign foreignMsg = snpValid && (snpSrc != SRC_W'(MY_ID));

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_ent
    snc_entry #(.DATA_W(DATA_W)) entry_i (
      .clk        (clk),
      .rstN       (rstN),
      .snpHit     (foreignMsg && snpObj == OBJ_W'(i)),
      .snpKind    (snpKind),
      .snpData    (snpData),
      .doWrite    (stb.localWrite && opObj == OBJ_W'(i)),
      .wrData     (opData),
      .doDowngrade(stb.sendVr && respObj == OBJ_W'(i)),
      .entSt      (entSt[i]),
      .entVal     (entVal[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opObj    <= '0;
      opData   <= '0;
      opWrite  <= 1'b0;
      respObj  <= '0;
      cpuRdata <= '0;
    end else begin
      if (stb.latchOp) begin
        opObj   <= cpuObj;
        opData  <= cpuWdata;
        opWrite <= cpuWrite;
      end
      if (stb.latchResp) respObj <= snpObj;
      if (stb.capHit)      cpuRdata <= entVal[opObj];
      else if (stb.capBus) cpuRdata <= snpData;
    end
  end

  assign opState   = entSt[opObj];
  assign snpHitOp  = foreignMsg && snpObj == opObj;
  assign snpRrHit  = foreignMsg && snpKind == MSG_RR && entSt[snpObj] != ST_INV;
  assign snpVrResp = foreignMsg && snpKind == MSG_VR && snpObj == respObj;
  assign snpVrOp   = foreignMsg && snpKind == MSG_VR && snpObj == opObj;
  assign outObj    = stb.sendVr ? respObj : opObj;
  assign outData   = stb.sendVr ? entVal[respObj] : opData;

endmodule

// File: rtl/snc_control.sv
module snc_control
  import snc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       busGrant,
  input  logic       opWrite,
  input  entState_e  opState,
  input  logic       snpHitOp,
  input  logic       snpRrHit,
  input  logic       snpVrResp,
  input  logic       snpVrOp,
  output ctlStrobe_t stb,
  output logic       cpuBusy,
  output logic       cpuRdValid,
  output logic       busReq,
  output logic       outValid,
  output logic [1:0] outKind
);

  typedef enum logic [1:0] {S_IDLE, S_OP, S_WAIT} fsm_e;

  fsm_e st, stNext;
  logic respPend;
  logic needBus, grantMe, localDone;

  assign needBus   = opWrite ? (opState != ST_EX) : (opState == ST_INV);
  assign busReq    = respPend || (st == S_OP && needBus);
  assign grantMe   = busGrant && busReq;
  assign localDone = st == S_OP && !respPend && !needBus && !snpHitOp;
  assign outValid  = grantMe;
  assign cpuBusy   = st != S_IDLE;

  always_comb begin
    if (!grantMe)      outKind = MSG_NONE;
    else if (respPend) outKind = MSG_VR;
    else if (opWrite)  outKind = MSG_WR;
    else               outKind = MSG_RR;
  end

  always_comb begin
    stb.latchOp    = st == S_IDLE && cpuReq;
    stb.latchResp  = snpRrHit && !respPend;
    stb.sendVr     = grantMe && respPend;
    stb.localWrite = opWrite && (localDone || (st == S_OP && grantMe && !respPend));
    stb.capHit     = !opWrite && localDone;
    stb.capBus     = st == S_WAIT && snpVrOp;
  end

  always_comb begin
    stNext = st;
    case (st)
      S_IDLE: if (cpuReq) stNext = S_OP;
      S_OP: begin
        if (localDone) stNext = S_IDLE;
        else if (grantMe && !respPend) stNext = opWrite ? S_IDLE : S_WAIT;
      end
      S_WAIT: if (snpVrOp) stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= S_IDLE;
      respPend   <= 1'b0;
      cpuRdValid <= 1'b0;
    end else begin
      st         <= stNext;
      cpuRdValid <= stb.capHit || stb.capBus;
      if (stb.sendVr || snpVrResp) respPend <= 1'b0;
      else if (snpRrHit)           respPend <= 1'b1;
    end
  end

endmodule

// File: rtl/snc_top.sv
module snc_top
  import snc_pkg::*;
#(
  parameter int OBJ_W  = 3,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [OBJ_W-1:0]  cpuObj,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuBusy,
  output logic              cpuRdValid,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic              outValid,
  output logic [1:0]        outKind,
  output logic [OBJ_W-1:0]  outObj,
  output logic [DATA_W-1:0] outData,
  output logic [SRC_W-1:0]  outSrc,
  input  logic              snpValid,
  input  logic [1:0]        snpKind,
  input  logic [OBJ_W-1:0]  snpObj,
  input  logic [DATA_W-1:0] snpData,
  input  logic [SRC_W-1:0]  snpSrc
);

  ctlStrobe_t stb;
  logic       opWrite;
  entState_e  opState;
  logic       snpHitOp, snpRrHit, snpVrResp, snpVrOp;

  assign outSrc = SRC_W'(MY_ID);

  snc_control control_i (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .busGrant  (busGrant),
    .opWrite   (opWrite),
    .opState   (opState),
    .snpHitOp  (snpHitOp),
    .snpRrHit  (snpRrHit),
    .snpVrResp (snpVrResp),
    .snpVrOp   (snpVrOp),
    .stb       (stb),
    .cpuBusy   (cpuBusy),
    .cpuRdValid(cpuRdValid),
    .busReq    (busReq),
    .outValid  (outValid),
    .outKind   (outKind)
  );

  snc_datapath #(
    .OBJ_W(OBJ_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cpuWrite (cpuWrite),
    .cpuObj   (cpuObj),
    .cpuWdata (cpuWdata),
    .snpValid (snpValid),
    .snpKind  (snpKind),
    .snpObj   (snpObj),
    .snpData  (snpData),
    .snpSrc   (snpSrc),
    .opWrite  (opWrite),
    .opState  (opState),
    .snpHitOp (snpHitOp),
    .snpRrHit (snpRrHit),
    .snpVrResp(snpVrResp),
    .snpVrOp  (snpVrOp),
    .outObj   (outObj),
    .outData  (outData),
    .cpuRdata (cpuRdata)
  );

endmodule

// File: rtl/snc_checker.sv
module snc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cpuReq,
  input logic       cpuBusy,
  input logic       cpuRdValid,
  input logic       busReq,
  input logic       busGrant,
  input logic       outValid,
  input logic [1:0] outKind
);

  // R5
  rr_waits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd1) |=> (cpuBusy && !cpuRdValid));

  // R4
  wr_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd2) |=> !cpuBusy);

  // R12
  rd_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdValid |-> ($past(cpuBusy) && !cpuBusy));

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuBusy && cpuReq) |=> cpuBusy);

  // R7
  vr_only_on_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busGrant && busReq && outKind != 2'd0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid) |-> (outKind == 2'd0));

endmodule

bind snc_top snc_checker checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .cpuReq    (cpuReq),
  .cpuBusy   (cpuBusy),
  .cpuRdValid(cpuRdValid),
  .busReq    (busReq),
  .busGrant  (busGrant),
  .outValid  (outValid),
  .outKind   (outKind)
);

// File: tb/snc_top_tb.sv
module snc_top_tb_top;
  import snc_pkg::*;

  localparam int OBJ_W = 3;
  localparam int DATA_W = 8;
  localparam int SRC_W = 2;
  localparam int MY_ID = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuWrite = 0;
  logic [OBJ_W-1:0] cpuObj = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuBusy, cpuRdValid, busReq, outValid;
  logic [DATA_W-1:0] cpuRdata, outData;
  logic busGrant = 0;
  logic [1:0] outKind;
  logic [OBJ_W-1:0] outObj;
  logic [SRC_W-1:0] outSrc;
  logic fValid = 0;
  logic [1:0] fKind = '0;
  logic [OBJ_W-1:0] fObj = '0;
  logic [DATA_W-1:0] fData = '0;
  logic [SRC_W-1:0] fSrc = '0;
  logic snpValid;
  logic [1:0] snpKind;
  logic [OBJ_W-1:0] snpObj;
  logic [DATA_W-1:0] snpData;
  logic [SRC_W-1:0] snpSrc;

  assign snpValid = busGrant ? outValid : fValid;
  assign snpKind  = busGrant ? outKind  : fKind;
  assign snpObj   = busGrant ? outObj   : fObj;
  assign snpData  = busGrant ? outData  : fData;
  assign snpSrc   = busGrant ? outSrc   : fSrc;

  always #4 clk = ~clk;

  snc_top #(.OBJ_W(OBJ_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuObj(cpuObj),
    .cpuWdata(cpuWdata), .cpuBusy(cpuBusy), .cpuRdValid(cpuRdValid), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGrant(busGrant), .outValid(outValid), .outKind(outKind),
    .outObj(outObj), .outData(outData), .outSrc(outSrc), .snpValid(snpValid),
    .snpKind(snpKind), .snpObj(snpObj), .snpData(snpData), .snpSrc(snpSrc));

  int checks = 0;
  int errors = 0;
  int nMsg;
  logic [1:0] firstK, gK;
  logic [OBJ_W-1:0] firstO, gO;
  logic [DATA_W-1:0] firstD, gD, rdOut;
  logic rdSeen, sawBusy;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic grantOne();
    busGrant = 1'b1;
    #1;
    gK = outKind; gO = outObj; gD = outData;
    @(negedge clk);
    busGrant = 1'b0;
  endtask

  task automatic foreign(input logic [1:0] k, input logic [OBJ_W-1:0] o,
                         input logic [DATA_W-1:0] d, input logic [SRC_W-1:0] s);
    @(negedge clk);
    fValid = 1'b1; fKind = k; fObj = o; fData = d; fSrc = s;
    @(negedge clk);
    fValid = 1'b0;
  endtask

  task automatic startOp(input logic w, input logic [OBJ_W-1:0] o, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = w; cpuObj = o; cpuWdata = d;
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int c = 0; c < 30; c++) begin
      if (!cpuBusy) break;
      @(negedge clk);
    end
    rdOut = cpuRdata;
    rdSeen = cpuRdValid;
  endtask

  // Runs one processor op; grants every request; answers each read request with memVal.
  task automatic doOp(input logic w, input logic [OBJ_W-1:0] o,
                      input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] memVal);
    nMsg = 0; sawBusy = 0; rdSeen = 0; firstK = '0;
    startOp(w, o, d);
    for (int c = 0; c < 30; c++) begin
      if (!cpuBusy) begin
        rdOut = cpuRdata; rdSeen = cpuRdValid;
        break;
      end
      sawBusy = 1'b1;
      if (busReq) begin
        grantOne();
        if (nMsg == 0) begin firstK = gK; firstO = gO; firstD = gD; end
        nMsg++;
        if (gK == MSG_RR) begin
          fValid = 1'b1; fKind = MSG_VR; fObj = o; fData = memVal; fSrc = 2'd3;
          @(negedge clk);
          fValid = 1'b0;
        end
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] mem, d1, d2, d3, mem2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cpuBusy && !busReq && !outValid, "R1 idle after reset", {cpuBusy, busReq, outValid}, 0);

    for (int o = 0; o < (1 << OBJ_W); o++) begin
      mem  = 8'(o * 29 + 3);
      d1   = 8'(o * 37 + 5);
      d2   = d1 ^ 8'hA5;
      d3   = 8'(o + 100);
      mem2 = 8'(o * 53 + 7);
      // R5 / R1: Invalid after reset, read goes to the bus
      doOp(1'b0, OBJ_W'(o), '0, mem);
      chk(nMsg == 1 && firstK == MSG_RR && firstO == OBJ_W'(o), "R5 read miss sends read request", nMsg, 1);
      chk(rdSeen && rdOut == mem, "R5 read miss data", rdOut, mem);
      chk(sawBusy, "R12 busy during op", sawBusy, 1);
      // R2
      doOp(1'b0, OBJ_W'(o), '0, 8'hEE);
      chk(nMsg == 0 && rdSeen && rdOut == mem, "R2 read hit read-only", rdOut, mem);
      // R4
      doOp(1'b1, OBJ_W'(o), d1, '0);
      chk(nMsg == 1 && firstK == MSG_WR && firstD == d1 && firstO == OBJ_W'(o), "R4 write from read-only", firstD, d1);
      // R3
      doOp(1'b1, OBJ_W'(o), d2, '0);
      chk(nMsg == 0, "R3 write exclusive local", nMsg, 0);
      doOp(1'b0, OBJ_W'(o), '0, 8'hEE);
      chk(nMsg == 0 && rdOut == d2, "R2 read hit exclusive", rdOut, d2);
      // R7 answer a foreign read request from Exclusive
      foreign(MSG_RR, OBJ_W'(o), '0, 2'd2);
      chk(busReq, "R7 response request", busReq, 1);
      grantOne();
      chk(gK == MSG_VR && gD == d2 && gO == OBJ_W'(o), "R7 value response", gD, d2);
      doOp(1'b1, OBJ_W'(o), d3, '0);
      chk(nMsg == 1 && firstK == MSG_WR, "R7 exclusive became read-only", nMsg, 1);
      // R6
      foreign(MSG_WR, OBJ_W'(o), '0, 2'd0);
      doOp(1'b0, OBJ_W'(o), '0, mem2);
      chk(nMsg == 1 && firstK == MSG_RR && rdOut == mem2, "R6 invalidated by write request", rdOut, mem2);
      // R10 own-source write request ignored
      foreign(MSG_WR, OBJ_W'(o), '0, 2'(MY_ID));
      doOp(1'b0, OBJ_W'(o), '0, 8'hEE);
      chk(nMsg == 0 && rdOut == mem2, "R10 own message ignored", rdOut, mem2);
    end

    // R8 pending response cancelled by another source's answer (object 5 read-only)
    foreign(MSG_RR, 3'd5, '0, 2'd2);
    chk(busReq, "R8 pending response", busReq, 1);
    foreign(MSG_VR, 3'd5, 8'(5 * 53 + 7), 2'd0);
    chk(!busReq, "R8 response dropped", busReq, 0);

    // R9 Invalid entry loads an observed value response (object 6)
    foreign(MSG_WR, 3'd6, '0, 2'd0);
    foreign(MSG_VR, 3'd6, 8'h99, 2'd0);
    doOp(1'b0, 3'd6, '0, 8'hEE);
    chk(nMsg == 0 && rdOut == 8'h99, "R9 value response loads invalid", rdOut, 8'h99);
    // R6 Invalid unaffected by write request: still needs the bus
    foreign(MSG_WR, 3'd6, '0, 2'd0);
    foreign(MSG_WR, 3'd6, '0, 2'd2);
    doOp(1'b0, 3'd6, '0, 8'h31);
    chk(nMsg == 1 && rdOut == 8'h31, "R6 invalid stays invalid", rdOut, 8'h31);

    // R11 lost arbitration to a write request, then retry as write request
    startOp(1'b1, 3'd2, 8'h3C);
    chk(busReq, "R11 write waits", busReq, 1);
    foreign(MSG_WR, 3'd2, '0, 2'd0);
    chk(busReq && cpuBusy, "R11 still requesting after invalidation", busReq, 1);
    grantOne();
    chk(gK == MSG_WR && gD == 8'h3C, "R11 retry is write request", gK, MSG_WR);
    waitDone();
    doOp(1'b0, 3'd2, '0, 8'hEE);
    chk(nMsg == 0 && rdOut == 8'h3C, "R11 winner exclusive", rdOut, 8'h3C);

    // R11 read satisfied by an observed value response before the grant
    foreign(MSG_WR, 3'd3, '0, 2'd0);
    startOp(1'b0, 3'd3, '0);
    chk(busReq, "R11 read waits", busReq, 1);
    foreign(MSG_VR, 3'd3, 8'h77, 2'd2);
    chk(!busReq, "R11 read no longer needs bus", busReq, 0);
    waitDone();
    chk(rdSeen && rdOut == 8'h77, "R11 read from observed response", rdOut, 8'h77);

    // R11 pending value response goes before own write request
    startOp(1'b1, 3'd4, 8'h42);
    foreign(MSG_RR, 3'd4, '0, 2'd2);
    grantOne();
    chk(gK == MSG_VR && gD == 8'(4 * 53 + 7), "R11 response first", gD, 4 * 53 + 7);
    chk(busReq, "R11 write still pending", busReq, 1);
    grantOne();
    chk(gK == MSG_WR && gD == 8'h42, "R11 write after response", gD, 8'h42);
    waitDone();
    chk(!cpuBusy, "R12 write completes", cpuBusy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule